// File: doc/BRIEF.md
# Sample-Only Boundary Scan Test Access Port

This block is the serial test port of a memory device. A four-wire test bus (clock, mode select, data in, data out) plus an optional asynchronous reset steers a sixteen-state controller. The controller moves bits through an instruction register and one of three data registers. The port can observe the device pads: a capture snapshots a vector of pad values into a boundary register, which is then shifted out. It can never drive a value into the core or onto a pad, so an update of the data register does nothing.

Two instructions capture pads exactly like the sample instruction and also raise a global request that tristates every device output. Because that request follows the active instruction, shifting a new code leaves it unchanged until the instruction update state. The identification instruction is active after reset and returns a fixed 32-bit code. Bypass and the three spare codes insert a single bit into the chain.

Controller states: ST_RESET, ST_IDLE, ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD, ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD. Transitions on tms=1 / tms=0: RESET→RESET/IDLE, IDLE→DR_SEL/IDLE, DR_SEL→IR_SEL/DR_CAP, DR_CAP→DR_EX1/DR_SHIFT, DR_SHIFT→DR_EX1/DR_SHIFT, DR_EX1→DR_UPD/DR_PAUSE, DR_PAUSE→DR_EX2/DR_PAUSE, DR_EX2→DR_UPD/DR_SHIFT, DR_UPD→DR_SEL/IDLE, IR_SEL→RESET/IR_CAP, IR_CAP→IR_EX1/IR_SHIFT, IR_SHIFT→IR_EX1/IR_SHIFT, IR_EX1→IR_UPD/IR_PAUSE, IR_PAUSE→IR_EX2/IR_PAUSE, IR_EX2→IR_UPD/IR_SHIFT, IR_UPD→DR_SEL/IDLE.

Top module: `scan_tap`

## Requirements
- R1: After trst_n low or in ST_RESET the active instruction is the identification code 3'b001; hiz_req and tdo_en are 0.
- R2: ST_IR_CAP loads the 3-bit instruction shift stage with 3'b001 (bits [1:0] = 01, bit 2 = 0); its bit 0 reaches tdo first.
- R3: In ST_IR_SHIFT the instruction stage shifts right with tdi entering bit 2; the active instruction, and with it hiz_req, changes only at the falling tck edge in ST_IR_UPD.
- R4: Code 3'b001 selects a 32-bit identification register that loads the ID_CODE parameter in ST_DR_CAP and shifts out bit 0 first.
- R5: Code 3'b100 selects the BSR_LEN-bit boundary register: ST_DR_CAP loads pad_in, ST_DR_SHIFT shifts right with tdi into the top bit, pad_in[0] leaving first; hiz_req stays 0.
- R6: ST_DR_UPD changes no register; a later capture returns fresh pad values, not the shifted-in data.
- R7: Code 3'b000 behaves like 3'b100 and also sets hiz_req to 1.
- R8: Code 3'b010 behaves like 3'b100 and also sets hiz_req to 1.
- R9: Code 3'b111 selects a 1-bit bypass register that captures 0, so tdo repeats tdi one shift later.
- R10: The spare codes 3'b011, 3'b101 and 3'b110 act as bypass with hiz_req 0.
- R11: tdo and tdo_en change on the falling tck edge; tdo_en is 1 exactly while the controller is in ST_IR_SHIFT or ST_DR_SHIFT.
- R12: Five consecutive rising edges with tms=1 reach ST_RESET from any state, with no use of trst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pad_in | input | BSR_LEN | Pad values observed by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| hiz_req | output | 1 | Request to tristate all device outputs |

## Verification
On every cycle, assertions check the controller's path into reset under a held tms and the capture values of the instruction stage, bypass bit and identification register. They also check that no register moves in the data update state, that the active instruction and the tristate request change only in the update or reset states, and that tdo_en matches the shift states. The serial ordering of captured data, the code-to-register mapping for all eight codes with their tristate effect, and the fresh pad snapshot after an update are shown only by the bench, which sweeps every instruction code under two pad patterns against a bit-level model.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
    } tap_state_e;

    localparam int INSN_W = 3;

    localparam logic [INSN_W-1:0] OP_HIZ_SAMPLE = 3'b000;
    localparam logic [INSN_W-1:0] OP_IDENT      = 3'b001;
    localparam logic [INSN_W-1:0] OP_SAMPLE_Z   = 3'b010;
    localparam logic [INSN_W-1:0] OP_SPARE_3    = 3'b011;
    localparam logic [INSN_W-1:0] OP_SAMPLE     = 3'b100;
    localparam logic [INSN_W-1:0] OP_SPARE_5    = 3'b101;
    localparam logic [INSN_W-1:0] OP_SPARE_6    = 3'b110;
    localparam logic [INSN_W-1:0] OP_BYPASS     = 3'b111;

    localparam logic [INSN_W-1:0] IR_CAPTURE_VAL = 3'b001;

    typedef enum logic [1:0] {
        DSEL_BYPASS,
        DSEL_IDENT,
        DSEL_BOUNDARY
    } dr_sel_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       shift_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       shift_dr,
    output logic       upd_dr
);

    tap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_d = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: state_d = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_d = tms ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_d = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: state_d = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_d = tms ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // output decode
    always_comb begin
        in_reset = 1'b0;
        cap_ir   = 1'b0;
        shift_ir = 1'b0;
        upd_ir   = 1'b0;
        cap_dr   = 1'b0;
        shift_dr = 1'b0;
        upd_dr   = 1'b0;
        unique case (state_q)
            ST_RESET:    in_reset = 1'b1;
            ST_IR_CAP:   cap_ir   = 1'b1;
            ST_IR_SHIFT: shift_ir = 1'b1;
            ST_IR_UPD:   upd_ir   = 1'b1;
            ST_DR_CAP:   cap_dr   = 1'b1;
            ST_DR_SHIFT: shift_dr = 1'b1;
            ST_DR_UPD:   upd_dr   = 1'b1;
            default:     ;
        endcase
    end

    assign state = state_q;

    // count of consecutive rising edges with tms high, used by the checks
    logic [2:0] tms_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          tms_run_q <= '0;
        else if (!tms)        tms_run_q <= '0;
        else if (tms_run_q != 3'd5) tms_run_q <= tms_run_q + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run_q == 3'd5) |-> (state_q == ST_RESET)); // R12
    AST_RESET_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET && tms) |=> (state_q == ST_RESET)); // R12

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              in_reset,
    input  logic              cap_ir,
    input  logic              shift_ir,
    input  logic              upd_ir,
    output logic              ir_lsb,
    output dr_sel_e           dr_sel,
    output logic              hiz_req
);

    logic [INSN_W-1:0] stage_q;
    logic [INSN_W-1:0] active_q;

    // shift stage, rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       stage_q <= IR_CAPTURE_VAL;
        else if (cap_ir)   stage_q <= IR_CAPTURE_VAL;
        else if (shift_ir) stage_q <= {tdi, stage_q[INSN_W-1:1]};
    end

    // active instruction, falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)       active_q <= OP_IDENT;
        else if (in_reset) active_q <= OP_IDENT;
        else if (upd_ir)   active_q <= stage_q;
    end

    always_comb begin
        dr_sel  = DSEL_BYPASS;
        hiz_req = 1'b0;
        unique case (active_q)
            OP_HIZ_SAMPLE: begin dr_sel = DSEL_BOUNDARY; hiz_req = 1'b1; end
            OP_SAMPLE_Z:   begin dr_sel = DSEL_BOUNDARY; hiz_req = 1'b1; end
            OP_SAMPLE:     dr_sel = DSEL_BOUNDARY;
            OP_IDENT:      dr_sel = DSEL_IDENT;
            OP_SPARE_3, OP_SPARE_5, OP_SPARE_6, OP_BYPASS: dr_sel = DSEL_BYPASS;
        endcase
    end

    assign ir_lsb = stage_q[0];

    AST_IR_CAPTURE_01: assert property (@(posedge tck) disable iff (!trst_n)
        cap_ir |=> (stage_q[1:0] == 2'b01)); // R2
    AST_ACTIVE_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (!upd_ir && !in_reset) |-> $stable(active_q)); // R3
    AST_HIZ_RISE_IN_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(hiz_req) |-> upd_ir); // R3
    AST_HIZ_CLEAR_IN_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        in_reset |=> !hiz_req); // R1

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 16,
    parameter logic [31:0] ID_CODE = 32'h1A5C_3E97
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               cap_dr,
    input  logic               shift_dr,
    input  logic               upd_dr,
    input  dr_sel_e            dr_sel,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic               dr_lsb
);

    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    logic sel_byp, sel_id, sel_bsr;
    assign sel_byp = (dr_sel == DSEL_BYPASS);
    assign sel_id  = (dr_sel == DSEL_IDENT);
    assign sel_bsr = (dr_sel == DSEL_BOUNDARY);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (cap_dr && sel_byp)  byp_q <= 1'b0;
        else if (shift_dr && sel_byp) byp_q <= tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 id_q <= ID_CODE;
        else if (cap_dr && sel_id)   id_q <= ID_CODE;
        else if (shift_dr && sel_id) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // snapshot only: nothing here is ever transferred to a pad
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                  bsr_q <= '0;
        else if (cap_dr && sel_bsr)   bsr_q <= pad_in;
        else if (shift_dr && sel_bsr) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
    end

    always_comb begin
        unique case (dr_sel)
            DSEL_IDENT:    dr_lsb = id_q[0];
            DSEL_BOUNDARY: dr_lsb = bsr_q[0];
            default:       dr_lsb = byp_q;
        endcase
    end

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && sel_byp) |=> !byp_q); // R9
    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && sel_id) |=> (id_q == ID_CODE)); // R4
    AST_UPDATE_DR_INERT: assert property (@(posedge tck) disable iff (!trst_n)
        upd_dr |=> ($stable(bsr_q) && $stable(id_q) && $stable(byp_q))); // R6

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 16,
    parameter logic [31:0] ID_CODE = 32'h1A5C_3E97
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               hiz_req
);

    tap_state_e state;
    logic in_reset, cap_ir, shift_ir, upd_ir, cap_dr, shift_dr, upd_dr;
    logic ir_lsb, dr_lsb;
    dr_sel_e dr_sel;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_ir(cap_ir), .shift_ir(shift_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .shift_ir(shift_ir), .upd_ir(upd_ir),
        .ir_lsb(ir_lsb), .dr_sel(dr_sel), .hiz_req(hiz_req)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .dr_sel(dr_sel),
        .pad_in(pad_in), .dr_lsb(dr_lsb)
    );

    // output retiming on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shift_ir | shift_dr;
            if (shift_ir)      tdo <= ir_lsb;
            else if (shift_dr) tdo <= dr_lsb;
        end
    end

    AST_TDO_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT)); // R11
    AST_SHIFT_HAS_TDO_EN: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_SHIFT || state == ST_DR_SHIFT) |-> tdo_en); // R11

endmodule

// File: tb/sim_scan_tap.sv
module sim_scan_tap;

    localparam int          NB  = 12;
    localparam logic [31:0] IDV = 32'h4B1D_2C6F;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [NB-1:0] pads = '0;
    logic tdo, tdo_en, hiz_req;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    scan_tap #(.BSR_LEN(NB), .ID_CODE(IDV)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .pad_in(pads), .tdo(tdo), .tdo_en(tdo_en), .hiz_req(hiz_req)
    );

    always #10 tck = ~tck;

    always @(posedge tck) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one tck period: sample outputs after falling edge, then drive
    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #2;
        o = tdo;
        e = tdo_en;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    // from idle: load an instruction, return captured bits and hiz before update
    task automatic ir_scan(input logic [2:0] code, output logic [2:0] outv,
                           output logic hiz_mid, output logic en_ok);
        logic o, e;
        en_ok = 1'b1;
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o, e);
            outv[i] = o;
            en_ok &= e;
        end
        step(1, 0, o, e);
        hiz_mid = hiz_req;
        en_ok &= !e;
        step(0, 0, o, e);
        en_ok &= !e;
    endtask

    task automatic dr_scan(input int n, input logic [63:0] din,
                           output logic [63:0] dout, output logic en_ok);
        logic o, e;
        en_ok = 1'b1;
        dout = '0;
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            en_ok &= e;
        end
        step(1, 0, o, e);
        en_ok &= !e;
        step(0, 0, o, e);
        en_ok &= !e;
    endtask

    function automatic int reg_len(input logic [2:0] c);
        if (c == 3'b001) return 32;
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return NB;
        return 1;
    endfunction

    function automatic logic [63:0] model(input logic [2:0] c, input logic [63:0] din,
                                          input int n, input logic [NB-1:0] p);
        logic [63:0] cap, r;
        int len;
        len = reg_len(c);
        cap = (c == 3'b001) ? 64'(IDV) : (len == NB) ? 64'(p) : 64'd0;
        r = '0;
        for (int i = 0; i < n; i++)
            r[i] = (i < len) ? cap[i] : din[i - len];
        return r;
    endfunction

    initial begin
        logic [2:0]  irout;
        logic [63:0] dout, din, expv;
        logic        hmid, en_ok, o, e, hiz_prev, hexp;
        string       tg;

        // R1: reset state
        #25;
        check(tdo_en == 1'b0, "R1 tdo_en in reset", 64'(tdo_en), 64'd0);
        check(hiz_req == 1'b0, "R1 hiz_req in reset", 64'(hiz_req), 64'd0);
        trst_n = 1'b1;
        step(0, 0, o, e);

        // R1 R4: identification active after reset
        din = 64'h00A5;
        dr_scan(40, din, dout, en_ok);
        expv = model(3'b001, din, 40, pads);
        check(dout[39:0] == expv[39:0], "R1 R4 default ident scan", dout, expv);
        check(en_ok, "R11 tdo_en during ident scan", 64'(en_ok), 64'd1);

        // sweep all codes with two pad patterns
        hiz_prev = 1'b0;
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [2:0] code;
                int n;
                code = 3'(c);
                ir_scan(code, irout, hmid, en_ok);
                check(irout == 3'b001, "R2 captured instruction", 64'(irout), 64'd1);
                check(hmid == hiz_prev, "R3 hiz held before update", 64'(hmid), 64'(hiz_prev));
                hexp = (code == 3'b000 || code == 3'b010);
                tg = (code == 3'b000) ? "R7" : (code == 3'b010) ? "R8" :
                     (code == 3'b111) ? "R9" : (code == 3'b100) ? "R5" :
                     (code == 3'b001) ? "R4" : "R10";
                check(hiz_req == hexp, {tg, " hiz after update"}, 64'(hiz_req), 64'(hexp));
                hiz_prev = hexp;
                check(en_ok, "R11 tdo_en during ir scan", 64'(en_ok), 64'd1);
                pads = NB'(c * 1237 + p * 2741 + 345);
                din  = 64'h9C3A_56E1_0F72_B4D8 ^ 64'(c * 77 + p);
                n    = reg_len(code) + 8;
                dr_scan(n, din, dout, en_ok);
                expv = model(code, din, n, pads);
                check(dout == expv, {tg, " data scan"}, dout, expv);
                check(en_ok, "R11 tdo_en during dr scan", 64'(en_ok), 64'd1);
            end
        end

        // R6: update after shifting data leaves no trace
        ir_scan(3'b100, irout, hmid, en_ok);
        din = 64'hFFF;
        pads = 12'h5A3;
        dr_scan(NB, din, dout, en_ok);
        pads = 12'h0C6;
        dr_scan(NB, 64'd0, dout, en_ok);
        check(dout[NB-1:0] == pads, "R6 capture after update", dout, 64'(pads));
        check(hiz_req == 1'b0, "R6 hiz unaffected by update", 64'(hiz_req), 64'd0);

        // R12: five tms ones from Shift-DR reach reset without trst_n
        ir_scan(3'b010, irout, hmid, en_ok);
        check(hiz_req == 1'b1, "R8 hiz before tms reset", 64'(hiz_req), 64'd1);
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 5; i++) step(1, 0, o, e);
        step(0, 0, o, e);
        check(hiz_req == 1'b0, "R12 hiz cleared by tms reset", 64'(hiz_req), 64'd0);
        din = 64'h3;
        dr_scan(34, din, dout, en_ok);
        expv = model(3'b001, din, 34, pads);
        check(dout[33:0] == expv[33:0], "R12 R1 ident after tms reset", dout, expv);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule